// File: doc/BRIEF.md
# Mixed-Latency Test Arithmetic Unit

This block is a 16-bit execution unit meant to exercise a computation-unit controller with operations of different latency. It takes an opcode and two operands through a valid/ready input handshake. It returns one result through a valid/ready output handshake.

Three opcodes take several cycles: add, multiply and logical shift-right. For these, the unit captures the operands when it accepts them. It then counts down a per-opcode latency, raises the output valid and holds the result until the consumer takes it. No new input is accepted during that time. Every other opcode is a subtraction that passes straight through in the same cycle, with no register on the path. Operand preparation, such as immediates, zeroing and inversion, happens upstream.

The controller has three states:
- `ST_IDLE`: waiting for work.
- `ST_RUN`: counting down.
- `ST_DONE`: result presented.

Its transitions are:
- `accept` (`ST_IDLE`→`ST_RUN`): a multi-cycle opcode is accepted.
- `expire` (`ST_RUN`→`ST_DONE`): the count reaches zero.
- `handoff` (`ST_DONE`→`ST_IDLE`): the output ready is seen high.
- The zero-delay subtraction never leaves `ST_IDLE`.

Top module: `mixlat_alu`

## Requirements
- R1: After reset the unit is in `ST_IDLE`: `out_valid` is 0, and `in_ready` is 1 while `in_op` holds a multi-cycle opcode.
- R2: Opcode 4'h1 (add) returns `(a + b) mod 2^16`. `out_valid` rises exactly `LAT_ADD` (default 2) clock edges after the accepting edge.
- R3: Opcode 4'h2 (multiply) returns the low 16 bits of `a * b`. `out_valid` rises `LAT_MUL` (default 4) edges after acceptance.
- R4: Opcode 4'h3 (shift-right) returns `a` logically shifted right by `b[3:0]`. `out_valid` rises `LAT_SHR` (default 3) edges after acceptance.
- R5: Any other opcode value (for example 4'h0 and 4'hF) returns `(a - b) mod 2^16` in the same cycle: in `ST_IDLE`, `out_valid` equals `in_valid` and `out_data` is the difference, with no clock edge between.
- R6: For a subtraction opcode in `ST_IDLE`, `in_ready` equals `out_ready` combinationally.
- R7: From the accepting edge of a multi-cycle opcode until the handoff edge, `in_ready` is 0. Any input presented meanwhile, including a subtraction, is ignored and does not change `out_data` or `out_valid`.
- R8: While a multi-cycle result is presented with `out_ready` low, `out_valid` stays 1 and `out_data` stays unchanged.
- R9: Operands and opcode are captured at the accepting edge. Later changes of `in_a`, `in_b` and `in_op` do not alter the result.
- R10: The cycle after the handoff edge, the unit is back in `ST_IDLE`: `out_valid` is 0 (with `in_valid` low) and `in_ready` is 1 for a multi-cycle opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Unit can take the presented operation |
| in_op | input | 4 | Opcode: 1 add, 2 multiply, 3 shift-right, others subtract |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Result |

## Verification
On the zero-delay path, acceptance of an operation and delivery of its result fall in the same cycle. Both are decided by one combinational path from `out_ready` to `in_ready`. The bench provokes this by holding a subtraction on the input with `out_ready` low, then raising `out_ready` without a clock edge. It judges that `out_valid` and `out_data` appear immediately and that `in_ready` tracks `out_ready` on each step. A second check presents a subtraction while a multi-cycle result is waiting. This confirms that the waiting result, not the difference, stays on the output.

// File: rtl/mixlat_pkg.sv
package mixlat_pkg;

    localparam int OP_W   = 4;
    localparam int DATA_W = 16;

    localparam logic [OP_W-1:0] OPC_ADD = 4'h1;
    localparam logic [OP_W-1:0] OPC_MUL = 4'h2;
    localparam logic [OP_W-1:0] OPC_SHR = 4'h3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mx_state_t;

    function automatic logic op_is_multi(input logic [OP_W-1:0] op);
        return (op == OPC_ADD) || (op == OPC_MUL) || (op == OPC_SHR);
    endfunction

endpackage

// File: rtl/mixlat_countdown.sv
module mixlat_countdown #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec_en,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_last,
    output logic             cnt_zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec_en && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign cnt_last = (cnt == CNT_W'(1));
    assign cnt_zero = (cnt == '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec_en && !cnt_zero) |=> (cnt == $past(cnt) - 1'b1)); // R2

endmodule

// File: rtl/mixlat_ctrl.sv
module mixlat_ctrl
    import mixlat_pkg::*;
#(
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 4,
    parameter int LAT_SHR = 3,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_op,
    input  logic             out_ready,
    input  logic             cnt_last,
    input  logic             cnt_zero,
    output logic             in_ready,
    output logic             out_valid,
    output logic             sel_held,
    output logic             accept,
    output logic             finish,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cnt_dec
);

    mx_state_t state_q, state_d;
    logic      multi;

    assign multi = op_is_multi(in_op);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid && multi) state_d = ST_RUN;
            ST_RUN:  if (cnt_last)          state_d = ST_DONE;
            ST_DONE: if (out_ready)         state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        sel_held  = 1'b0;
        accept    = 1'b0;
        finish    = 1'b0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        unique case (in_op)
            OPC_ADD: cnt_val = CNT_W'(LAT_ADD);
            OPC_MUL: cnt_val = CNT_W'(LAT_MUL);
            OPC_SHR: cnt_val = CNT_W'(LAT_SHR);
            default: cnt_val = '0;
        endcase
        unique case (state_q)
            ST_IDLE: begin
                if (multi) begin
                    in_ready = 1'b1;
                    accept   = in_valid;
                    cnt_load = in_valid;
                end else begin
                    in_ready  = out_ready;
                    out_valid = in_valid;
                end
            end
            ST_RUN: begin
                cnt_dec = 1'b1;
                finish  = cnt_last;
            end
            ST_DONE: begin
                out_valid = 1'b1;
                sel_held  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !in_ready); // R7
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> cnt_zero); // R2
    AST_ZERO_PATH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid && !multi) |-> (out_valid && in_ready == out_ready)); // R6
    AST_HANDOFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && out_ready) |=> (state_q == ST_IDLE)); // R10

endmodule

// File: rtl/mixlat_datapath.sv
module mixlat_datapath
    import mixlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              finish,
    input  logic              sel_held,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic [DATA_W-1:0] out_data
);

    localparam int SH_W = $clog2(DATA_W);

    logic [OP_W-1:0]     op_q;
    logic [DATA_W-1:0]   a_q, b_q, res_q, mc_res, diff;
    logic [2*DATA_W-1:0] prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
        end else if (accept) begin
            op_q <= in_op;
            a_q  <= in_a;
            b_q  <= in_b;
        end
    end

    assign prod = a_q * b_q;

    always_comb begin
        unique case (op_q)
            OPC_ADD: mc_res = a_q + b_q;
            OPC_MUL: mc_res = prod[DATA_W-1:0];
            OPC_SHR: mc_res = a_q >> b_q[SH_W-1:0];
            default: mc_res = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      res_q <= '0;
        else if (finish) res_q <= mc_res;
    end

    assign diff     = in_a - in_b;
    assign out_data = sel_held ? res_q : diff;

    AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept) |=> ($stable(a_q) && $stable(b_q) && $stable(op_q))); // R9

endmodule

// File: rtl/mixlat_alu.sv
module mixlat_alu
    import mixlat_pkg::*;
#(
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 4,
    parameter int LAT_SHR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    localparam int LAT_MAX = (LAT_ADD > LAT_MUL) ?
                             ((LAT_ADD > LAT_SHR) ? LAT_ADD : LAT_SHR) :
                             ((LAT_MUL > LAT_SHR) ? LAT_MUL : LAT_SHR);
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    logic             accept, finish, sel_held;
    logic             cnt_load, cnt_dec, cnt_last, cnt_zero;
    logic [CNT_W-1:0] cnt_val, cnt;

    mixlat_ctrl #(
        .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_SHR(LAT_SHR), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .out_ready(out_ready), .cnt_last(cnt_last), .cnt_zero(cnt_zero),
        .in_ready(in_ready), .out_valid(out_valid), .sel_held(sel_held),
        .accept(accept), .finish(finish), .cnt_load(cnt_load),
        .cnt_val(cnt_val), .cnt_dec(cnt_dec)
    );

    mixlat_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .dec_en(cnt_dec), .cnt(cnt), .cnt_last(cnt_last), .cnt_zero(cnt_zero)
    );

    mixlat_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .finish(finish),
        .sel_held(sel_held), .in_op(in_op), .in_a(in_a), .in_b(in_b),
        .out_data(out_data)
    );

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_held && !out_ready) |=> (out_valid && $stable(out_data))); // R8
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |-> (cnt_val != '0)); // R2

endmodule

// File: tb/tb_mixlat_alu.sv
module tb_mixlat_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_op = 4'h1;
    logic [15:0] in_a = '0;
    logic [15:0] in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mixlat_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Multi-cycle operation: latency, capture, hold and handoff
    task automatic run_multi(input string req, input logic [3:0] op,
                             input logic [15:0] a, input logic [15:0] b,
                             input logic [15:0] exp, input int lat);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; out_ready = 1'b0;
        #1;
        check({req, " ready before accept"}, 16'(in_ready), 16'd1);
        @(posedge clk);
        for (int k = 0; k <= lat; k++) begin
            @(negedge clk);
            if (k == 0) begin
                // R9: scramble inputs after acceptance
                in_valid = 1'b0; in_op = 4'h2; in_a = 16'hDEAD; in_b = 16'h0BEE;
            end
            if (k < lat) begin
                check({req, " valid low while counting"}, 16'(out_valid), 16'd0);
                check("R7 ready low while busy", 16'(in_ready), 16'd0);
            end else begin
                check({req, " valid at latency"}, 16'(out_valid), 16'd1);
                check({req, " R9 result"}, out_data, exp);
            end
        end
        // R8 / R7: hold with out_ready low, a subtraction presented meanwhile
        in_valid = 1'b1; in_op = 4'h0; in_a = 16'h0009; in_b = 16'h0001;
        repeat (2) begin
            @(negedge clk);
            check("R8 held valid", 16'(out_valid), 16'd1);
            check("R8 held data", out_data, exp);
            check("R7 sub ignored while done", 16'(in_ready), 16'd0);
        end
        in_valid = 1'b0; in_op = 4'h1; out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        check("R10 idle valid", 16'(out_valid), 16'd0);
        check("R10 idle ready", 16'(in_ready), 16'd1);
    endtask

    // Zero-delay subtraction: same-cycle result and ready follows out_ready
    task automatic run_sub(input logic [3:0] op, input logic [15:0] a,
                           input logic [15:0] b);
        @(negedge clk);
        in_valid = 1'b0; in_op = op; in_a = a; in_b = b; out_ready = 1'b0;
        #1;
        check("R5 valid follows in_valid low", 16'(out_valid), 16'd0);
        in_valid = 1'b1;
        #1;
        check("R5 valid same cycle", 16'(out_valid), 16'd1);
        check("R5 difference", out_data, 16'(a - b));
        check("R6 ready low with out_ready low", 16'(in_ready), 16'd0);
        out_ready = 1'b1;
        #1;
        check("R6 ready high with out_ready high", 16'(in_ready), 16'd1);
        @(negedge clk);
        check("R5 still idle after edge", out_data, 16'(a - b));
        in_valid = 1'b0; out_ready = 1'b0; in_op = 4'h1;
    endtask

    task automatic run_reset;
        #1;
        check("R1 valid low in reset", 16'(out_valid), 16'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid low after reset", 16'(out_valid), 16'd0);
        check("R1 ready after reset", 16'(in_ready), 16'd1);
    endtask

    initial begin
        fork
            begin
                run_reset();
                run_multi("R2", 4'h1, 16'd5, 16'd2, 16'd7, 2);
                run_multi("R2", 4'h1, 16'hFFFF, 16'd3, 16'd2, 2);
                run_multi("R3", 4'h2, 16'd300, 16'd300, 16'd24464, 4);
                run_multi("R3", 4'h2, 16'd3, 16'd4, 16'd12, 4);
                run_multi("R4", 4'h3, 16'h8000, 16'd15, 16'h0001, 3);
                run_multi("R4", 4'h3, 16'hF0F0, 16'h0014, 16'h0F0F, 3);
                run_sub(4'h0, 16'd5, 16'd2);
                run_sub(4'hF, 16'd2, 16'd5);
                run_sub(4'h7, 16'h1234, 16'h0234);
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_chk++; n_bad++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule